// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address stream for a four-beat burst into a synchronous memory. A start address is captured whenever either of two address strobes is active at a rising clock edge. One strobe belongs to the processor side and the other to the memory controller side, and both have the same effect. After that capture, the two low address bits are generated internally. They move forward one beat on each clock where the advance input is high and stay put otherwise. The upper address bits keep the captured value for the whole burst.

A static order input selects one of two beat sequences. In interleaved order, the low bits are the captured low bits XOR a two-bit beat count. In linear order, they are the captured low bits plus the beat count, modulo four. Either way, the low field wraps inside its four-address block and never carries into the upper bits. The current beat count is also driven out so that downstream logic can tell where it is within the burst.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous active-high reset clears the state, so that on the cycle after a reset edge `addr_out` is 0 and `beat` is 0.
- R2: When `strobe_cpu` is high at a rising edge, the next cycle shows `addr_out` equal to the sampled `addr_in` and `beat` equal to 0.
- R3: When `strobe_ctl` is high at a rising edge, it loads the address in the same way as `strobe_cpu`, with or without the other strobe.
- R4: When both strobes are low and `adv` is high at a rising edge, `beat` increases by one, modulo 4.
- R5: With `order_il` = 1 (interleaved), `addr_out[1:0]` equals the captured low bits XOR `beat`.
- R6: With `order_il` = 0 (linear), `addr_out[1:0]` equals the captured low bits plus `beat`, modulo 4.
- R7: Until the next strobe, the upper bits `addr_out[ADDR_W-1:2]` keep the value captured at the last load.
- R8: When both strobes and `adv` are low at a rising edge, `beat` and `addr_out` keep their values, provided `order_il` does not change.
- R9: A strobe takes priority over `adv`: if both are high, the address reloads and `beat` returns to 0.
- R10: Advancing past beat 3 wraps to beat 0, which gives the start address again with no carry into the upper bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_cpu | input | 1 | Processor-side address strobe; loads `addr_in` |
| strobe_ctl | input | 1 | Controller-side address strobe; loads `addr_in` |
| adv | input | 1 | Advance to the next beat when no strobe is active |
| order_il | input | 1 | 1 selects interleaved order, 0 selects linear order |
| addr_in | input | ADDR_W | Start address captured on a strobe |
| addr_out | output | ADDR_W | Current burst address |
| beat | output | 2 | Position within the burst, 0 to 3 |

## Verification
The address properties assume that `order_il` behaves as a static strapping input. Each property that compares `addr_out` across an edge therefore excuses any cycle in which the order input changed. The stimulus keeps the order fixed over long stretches of random load, advance and hold cycles, and changes it only between segments. Apart from that, the strobes, `adv` and `addr_in` may take any value in any cycle, including both strobes together and a strobe together with `adv`.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } action_e;

    function automatic action_e pick_action(input logic s_a, input logic s_b, input logic step);
        if (s_a || s_b) begin
            return ACT_LOAD;
        end else if (step) begin
            return ACT_STEP;
        end
        return ACT_HOLD;
    endfunction

    function automatic beat_t low_bits(input beat_t start, input beat_t cnt, input order_e ord);
        beat_t r;
        if (ord == ORDER_INTERLEAVED) begin
            r = start ^ cnt;
        end else begin
            r = start + cnt;
        end
        return r;
    endfunction

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import burst_seq_pkg::*;
(
    input  logic    strobe_a,
    input  logic    strobe_b,
    input  logic    step,
    output action_e act
);
    always_comb begin
        act = pick_action(strobe_a, strobe_b, step);
    end
endmodule

// File: rtl/bseq_state.sv
module bseq_state
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  action_e           act,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-BEAT_W-1:0] upper_q,
    output beat_t             start_q,
    output beat_t             beat_q
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        beat_t              start;
        beat_t              cnt;
    } burst_state_t;

    burst_state_t cur, nxt;

    always_comb begin
        nxt = cur;
        unique case (act)
            ACT_LOAD: begin
                nxt.upper = load_addr[ADDR_W-1:BEAT_W];
                nxt.start = load_addr[BEAT_W-1:0];
                nxt.cnt   = '0;
            end
            ACT_STEP: nxt.cnt = cur.cnt + beat_t'(1);
            default:  nxt = cur;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

    assign upper_q = cur.upper;
    assign start_q = cur.start;
    assign beat_q  = cur.cnt;
endmodule

// File: rtl/bseq_map.sv
module bseq_map
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic [ADDR_W-BEAT_W-1:0] upper,
    input  beat_t                    start,
    input  beat_t                    cnt,
    input  logic                     order_sel,
    output logic [ADDR_W-1:0]        addr
);
    beat_t lo;

    always_comb begin
        lo   = low_bits(start, cnt, order_e'(order_sel));
        addr = {upper, lo};
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              adv,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    action_e            act;
    logic [UPPER_W-1:0] upper_q;
    beat_t              start_q;
    beat_t              beat_q;

    bseq_ctrl u_ctrl (
        .strobe_a (strobe_cpu),
        .strobe_b (strobe_ctl),
        .step     (adv),
        .act      (act)
    );

    bseq_state #(.ADDR_W(ADDR_W)) u_state (
        .clk       (clk),
        .rst       (rst),
        .act       (act),
        .load_addr (addr_in),
        .upper_q   (upper_q),
        .start_q   (start_q),
        .beat_q    (beat_q)
    );

    bseq_map #(.ADDR_W(ADDR_W)) u_map (
        .upper     (upper_q),
        .start     (start_q),
        .cnt       (beat_q),
        .order_sel (order_il),
        .addr      (addr_out)
    );

    assign beat = beat_q;
endmodule

// File: rtl/bseq_checker.sv
module bseq_checker #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              strobe_cpu,
    input logic              strobe_ctl,
    input logic              adv,
    input logic              order_il,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic [1:0]        beat
);
    logic any_strobe;
    assign any_strobe = strobe_cpu || strobe_ctl;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (beat == 2'd0 && addr_out == '0));

    p_load_cpu_r2: assert property (@(posedge clk) disable iff (rst)
        strobe_cpu |=> (beat == 2'd0 && addr_out == $past(addr_in)));

    p_load_ctl_r3: assert property (@(posedge clk) disable iff (rst)
        strobe_ctl |=> (beat == 2'd0 && addr_out == $past(addr_in)));

    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!any_strobe && adv) |=> (beat == 2'($past(beat) + 2'd1)));

    p_il_order_r5: assert property (@(posedge clk) disable iff (rst)
        (!any_strobe && adv && order_il) |=>
            (!$stable(order_il) ||
             ((addr_out[1:0] ^ $past(addr_out[1:0])) == (beat ^ $past(beat)))));

    p_lin_order_r6: assert property (@(posedge clk) disable iff (rst)
        (!any_strobe && adv && !order_il) |=>
            (!$stable(order_il) || (addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1))));

    p_upper_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !any_strobe |=> $stable(addr_out[ADDR_W-1:2]));

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!any_strobe && !adv) |=> ($stable(beat) && (!$stable(order_il) || $stable(addr_out))));

    p_strobe_first_r9: assert property (@(posedge clk) disable iff (rst)
        (any_strobe && adv) |=> (beat == 2'd0));

    p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (!any_strobe && adv && beat == 2'd3) |=> (beat == 2'd0));
endmodule

bind burst_addr_seq bseq_checker #(.ADDR_W(ADDR_W)) u_bseq_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .adv        (adv),
    .order_il   (order_il),
    .addr_in    (addr_in),
    .addr_out   (addr_out),
    .beat       (beat)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
    localparam int ADDR_W = 18;
    localparam int UW = ADDR_W - 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strobe_cpu = 1'b0, strobe_ctl = 1'b0, adv = 1'b0, order_il = 1'b1;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic [1:0] beat;

    int errors = 0;
    int checks = 0;

    logic [UW-1:0] m_upper;
    logic [1:0]    m_start;
    logic [1:0]    m_beat;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
        .adv(adv), .order_il(order_il), .addr_in(addr_in),
        .addr_out(addr_out), .beat(beat)
    );

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] b, input logic il);
        return il ? (s ^ b) : 2'(s + b);
    endfunction

    function automatic logic [ADDR_W-1:0] exp_addr();
        return {m_upper, exp_low(m_start, m_beat, order_il)};
    endfunction

    task automatic chk(input string tag, input logic [ADDR_W-1:0] got, input logic [ADDR_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive inputs after a falling edge, advance one rising edge, update model, sample at the next falling edge.
    task automatic cycle(input logic sa, input logic sb, input logic ad, input logic [ADDR_W-1:0] a);
        strobe_cpu = sa; strobe_ctl = sb; adv = ad; addr_in = a;
        @(posedge clk);
        if (sa || sb) begin
            m_upper = a[ADDR_W-1:2]; m_start = a[1:0]; m_beat = 2'd0;
        end else if (ad) begin
            m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        m_upper = '0; m_start = '0; m_beat = '0;
        @(negedge clk); @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 addr", addr_out, '0);
        chk("R1 beat", {16'd0, beat}, '0);
        rst = 1'b0;

        // R2 + R5 + R10: interleaved from low bits 2 -> 2,3,0,1 then wrap to 2
        order_il = 1'b1;
        cycle(1, 0, 0, 18'h2A5F6);
        chk("R2 load", addr_out, 18'h2A5F6);
        chk("R2 beat", {16'd0, beat}, 18'd0);
        cycle(0, 0, 1, '0); chk("R5 il b1", addr_out, 18'h2A5F7);
        cycle(0, 0, 1, '0); chk("R5 il b2", addr_out, 18'h2A5F4);
        cycle(0, 0, 1, '0); chk("R5 il b3", addr_out, 18'h2A5F5);
        cycle(0, 0, 1, '0); chk("R10 wrap", addr_out, 18'h2A5F6);
        chk("R10 beat", {16'd0, beat}, 18'd0);

        // R3 + R6 + R7: linear from low bits 3 -> 3,0,1,2 with upper fixed
        order_il = 1'b0;
        cycle(0, 1, 0, 18'h1003B);
        chk("R3 load", addr_out, 18'h1003B);
        cycle(0, 0, 1, '0); chk("R6 lin b1", addr_out, 18'h10038);
        cycle(0, 0, 1, '0); chk("R6 lin b2", addr_out, 18'h10039);
        cycle(0, 0, 1, '0); chk("R7 upper", addr_out, 18'h1003A);

        // R8 hold
        cycle(0, 0, 0, 18'h3FFFF); chk("R8 hold", addr_out, 18'h1003A);
        chk("R8 beat", {16'd0, beat}, 18'd3);

        // R9 strobe beats advance; both strobes together
        cycle(1, 1, 1, 18'h00C41);
        chk("R9 reload", addr_out, 18'h00C41);
        chk("R9 beat", {16'd0, beat}, 18'd0);

        // random segments, order fixed inside each
        for (int seg = 0; seg < 8; seg++) begin
            order_il = seg[0];
            for (int i = 0; i < 150; i++) begin
                logic sa, sb, ad;
                logic [ADDR_W-1:0] a;
                string tag;
                sa = ($urandom % 8) == 0;
                sb = ($urandom % 8) == 0;
                ad = ($urandom % 3) != 0;
                a  = ADDR_W'($urandom);
                tag = (sa || sb) ? "R2/R3 rnd" : (ad ? (order_il ? "R4/R5 rnd" : "R4/R6 rnd") : "R8 rnd");
                cycle(sa, sb, ad, a);
                chk(tag, addr_out, exp_addr());
                chk("R4 beat rnd", {16'd0, beat}, {16'd0, m_beat});
            end
        end

        // reset mid-burst
        cycle(0, 0, 1, '0);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        m_upper = '0; m_start = '0; m_beat = '0;
        chk("R1 mid", addr_out, '0);
        rst = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule